// File: doc/BRIEF.md
# Atomic period power accumulator

The block gathers signed real-power samples, one per completed measurement window, into a live period accumulator. It keeps an import sum, an export sum, a window count, a running peak and a millisecond timer. A single latch pulse closes the current period and opens the next one in the same clock edge. The live totals move into a held snapshot, the live side restarts from empty, and no sample is lost or counted twice.

The snapshot gives the window count, the peak power, the elapsed milliseconds and a valid flag. A pair of restoring dividers, started by the latch, turns the two sums into average import and export power. Software reads the averages once the busy flag drops. Energy is obtained by multiplying an average by a period length that is measured elsewhere. The elapsed-time output serves only as a drift cross-check.

Top module: `period_acc`

## Requirements
- R1: On a latch edge the snapshot takes the live count, peak, timer and sums, and the live side starts an empty period in that same edge.
- R2: A sample strobed in the same cycle as a latch is counted only in the period that the latch opens.
- R3: count_o, peak_o, elapsed_ms_o and valid_o change only on a latch edge. Samples and ticks between latches leave them untouched.
- R4: valid_o is 1 exactly when the closed period holds at least one committed window.
- R5: count_o is the number of committed windows. Once the live count reaches its maximum (2^CNT_W-1), further samples are ignored entirely and change no sum, count or peak.
- R6: peak_o is the largest signed sample committed in the closed period, and 0 when none was committed.
- R7: elapsed_ms_o is the number of tick_i pulses in the period, saturating at 2^MS_W-1. A tick in the latch cycle counts toward the new period.
- R8: With bidir_i = 0 at a sample's strobe, a positive sample adds to the import sum and a negative sample adds to neither sum. The sample is still counted and still competes for the peak.
- R9: With bidir_i = 1, positive samples add to the import sum and the magnitude of each negative sample adds to the export sum.
- R10: avg_import_o and avg_export_o equal floor(sum / count) of the closed period, and 0 when the count is 0. busy_o rises on the cycle after a latch and falls when both averages are updated, SUM_W cycles later.
- R11: The first latch after reset closes a period that began at reset, and its snapshot reflects everything committed since reset.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One completed power window is present on sample_i |
| sample_i | input | SAMPLE_W | Signed two's-complement window power |
| bidir_i | input | 1 | 1: negative samples feed the export sum |
| tick_i | input | 1 | One-millisecond pulse |
| latch_i | input | 1 | Close the current period and open the next |
| avg_import_o | output | SAMPLE_W | Mean import power of the closed period |
| avg_export_o | output | SAMPLE_W | Mean export magnitude of the closed period |
| peak_o | output | SAMPLE_W | Signed peak sample of the closed period |
| elapsed_ms_o | output | MS_W | Ticks counted in the closed period |
| count_o | output | CNT_W | Committed windows in the closed period |
| valid_o | output | 1 | Closed period is not empty |
| busy_o | output | 1 | Averages are being computed |

## Verification
Mixed-sign bursts are sent with the direction bit both off and on. This separates dropped negative samples from exported ones, and shows that dropped samples still count and still set the peak. All-negative periods check that the peak is taken as a signed maximum. Empty periods check the zero forcing of the average and the peak.

Samples and ticks placed exactly on the latch cycle check the boundary rule. Strobes sent after the count fills check that they are ignored, and a long run of ticks checks timer saturation. A sweep of 31 consecutive periods, growing from 1 to 31 samples with varied values and alternating direction mode, compares every snapshot field and both quotients with arithmetic done in the bench.

// File: rtl/period_acc_pkg.sv
package period_acc_pkg;
  typedef enum logic [1:0] {
    SMP_IMPORT = 2'd0,
    SMP_EXPORT = 2'd1,
    SMP_DROP   = 2'd2
  } smp_class_e;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/pa_live_acc.sv
module pa_live_acc
  import period_acc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SUM_W    = 48,
  parameter int CNT_W    = 16,
  parameter int MS_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       bidir_i,
  input  logic                       tick_i,
  input  logic                       latch_i,
  output logic        [SUM_W-1:0]    live_imp_o,
  output logic        [SUM_W-1:0]    live_exp_o,
  output logic        [CNT_W-1:0]    live_cnt_o,
  output logic signed [SAMPLE_W-1:0] live_peak_o,
  output logic        [MS_W-1:0]     live_ms_o
);
  localparam int PAD = SUM_W - SAMPLE_W - 1;
  localparam logic signed [SAMPLE_W-1:0] PEAK_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [MS_W-1:0]  MS_ONE  = MS_W'(1);

  logic        [SUM_W-1:0]    imp_q, exp_q;
  logic        [CNT_W-1:0]    cnt_q;
  logic signed [SAMPLE_W-1:0] peak_q;
  logic        [MS_W-1:0]     ms_q;

  smp_class_e                 cls;
  logic                       neg, take;
  logic        [SAMPLE_W:0]   mag;
  logic        [SUM_W-1:0]    add_val;
  logic        [SUM_W-1:0]    base_imp, base_exp;
  logic        [CNT_W-1:0]    base_cnt;
  logic signed [SAMPLE_W-1:0] base_peak;

  assign neg = sample_i[SAMPLE_W-1];

  always_comb begin
    if (!neg)        cls = SMP_IMPORT;
    else if (bidir_i) cls = SMP_EXPORT;
    else             cls = SMP_DROP;
  end

  assign mag     = neg ? -{sample_i[SAMPLE_W-1], sample_i} : {1'b0, sample_i};
  assign add_val = {{PAD{1'b0}}, mag};

  // latch empties the period first, so a saturated count never blocks the new sample
  assign take = sample_valid_i && (latch_i || !(&cnt_q));

  assign base_imp  = latch_i ? '0       : imp_q;
  assign base_exp  = latch_i ? '0       : exp_q;
  assign base_cnt  = latch_i ? '0       : cnt_q;
  assign base_peak = latch_i ? PEAK_MIN : peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imp_q  <= '0;
      exp_q  <= '0;
      cnt_q  <= '0;
      peak_q <= PEAK_MIN;
      ms_q   <= '0;
    end else begin
      imp_q  <= (take && cls == SMP_IMPORT) ? base_imp + add_val : base_imp;
      exp_q  <= (take && cls == SMP_EXPORT) ? base_exp + add_val : base_exp;
      cnt_q  <= take ? base_cnt + CNT_ONE : base_cnt;
      peak_q <= (take && (sample_i > base_peak)) ? sample_i : base_peak;
      if (latch_i)                ms_q <= tick_i ? MS_ONE : '0;
      else if (tick_i && !(&ms_q)) ms_q <= ms_q + MS_ONE;
    end
  end

  assign live_imp_o  = imp_q;
  assign live_exp_o  = exp_q;
  assign live_cnt_o  = cnt_q;
  assign live_peak_o = peak_q;
  assign live_ms_o   = ms_q;
endmodule

// File: rtl/pa_snapshot.sv
module pa_snapshot #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 16,
  parameter int MS_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       latch_i,
  input  logic        [CNT_W-1:0]    live_cnt_i,
  input  logic signed [SAMPLE_W-1:0] live_peak_i,
  input  logic        [MS_W-1:0]     live_ms_i,
  output logic        [CNT_W-1:0]    cnt_o,
  output logic signed [SAMPLE_W-1:0] peak_o,
  output logic        [MS_W-1:0]     ms_o,
  output logic                       valid_o
);
  logic empty;
  assign empty = (live_cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      peak_o  <= '0;
      ms_o    <= '0;
      valid_o <= 1'b0;
    end else if (latch_i) begin
      cnt_o   <= live_cnt_i;
      peak_o  <= empty ? '0 : live_peak_i;
      ms_o    <= live_ms_i;
      valid_o <= !empty;
    end
  end
endmodule

// File: rtl/pa_divider.sv
module pa_divider
  import period_acc_pkg::*;
#(
  parameter int N_W = 48,
  parameter int D_W = 16,
  parameter int Q_W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           busy_o,
  output logic [Q_W-1:0] quot_o
);
  localparam int STEP_W = $clog2(N_W + 1);
  localparam logic [STEP_W-1:0] STEPS    = STEP_W'(N_W);
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

  div_state_e        state_q;
  logic [N_W-1:0]    q_q, q_n;
  logic [D_W:0]      rem_q, rem_n, shifted, den_ext, diff;
  logic [D_W-1:0]    den_q;
  logic [STEP_W-1:0] step_q;
  logic              zero_q, fits;
  logic [Q_W-1:0]    quot_q;

  assign den_ext = {1'b0, den_q};
  assign shifted = {rem_q[D_W-1:0], q_q[N_W-1]};
  assign diff    = shifted - den_ext;
  assign fits    = (shifted >= den_ext);
  assign rem_n   = fits ? diff : shifted;
  assign q_n     = {q_q[N_W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      q_q     <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      zero_q  <= 1'b0;
      quot_q  <= '0;
    end else if (start_i) begin
      state_q <= DIV_RUN;
      q_q     <= num_i;
      rem_q   <= '0;
      den_q   <= den_i;
      step_q  <= STEPS;
      zero_q  <= (den_i == '0);
    end else if (state_q == DIV_RUN) begin
      q_q    <= q_n;
      rem_q  <= rem_n;
      step_q <= step_q - STEP_ONE;
      if (step_q == STEP_ONE) begin
        state_q <= DIV_IDLE;
        quot_q  <= zero_q ? '0 : q_n[Q_W-1:0];
      end
    end
  end

  assign busy_o = (state_q == DIV_RUN);
  assign quot_o = quot_q;
endmodule

// File: rtl/period_acc.sv
module period_acc #(
  parameter int SAMPLE_W = 24,
  parameter int SUM_W    = 48,
  parameter int CNT_W    = 16,
  parameter int MS_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       bidir_i,
  input  logic                       tick_i,
  input  logic                       latch_i,
  output logic        [SAMPLE_W-1:0] avg_import_o,
  output logic        [SAMPLE_W-1:0] avg_export_o,
  output logic signed [SAMPLE_W-1:0] peak_o,
  output logic        [MS_W-1:0]     elapsed_ms_o,
  output logic        [CNT_W-1:0]    count_o,
  output logic                       valid_o,
  output logic                       busy_o
);
  localparam int N_DIV = 2;

  logic        [SUM_W-1:0]    live_imp, live_exp;
  logic        [CNT_W-1:0]    live_cnt;
  logic signed [SAMPLE_W-1:0] live_peak;
  logic        [MS_W-1:0]     live_ms;

  logic [SUM_W-1:0]    div_num  [N_DIV];
  logic [SAMPLE_W-1:0] div_quot [N_DIV];
  logic [N_DIV-1:0]    div_busy;

  pa_live_acc #(
    .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .CNT_W(CNT_W), .MS_W(MS_W)
  ) u_live (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .bidir_i        (bidir_i),
    .tick_i         (tick_i),
    .latch_i        (latch_i),
    .live_imp_o     (live_imp),
    .live_exp_o     (live_exp),
    .live_cnt_o     (live_cnt),
    .live_peak_o    (live_peak),
    .live_ms_o      (live_ms)
  );

  pa_snapshot #(
    .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .MS_W(MS_W)
  ) u_snap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch_i),
    .live_cnt_i  (live_cnt),
    .live_peak_i (live_peak),
    .live_ms_i   (live_ms),
    .cnt_o       (count_o),
    .peak_o      (peak_o),
    .ms_o        (elapsed_ms_o),
    .valid_o     (valid_o)
  );

  assign div_num[0] = live_imp;
  assign div_num[1] = live_exp;

  // dividers load the pre-latch live totals on the latch edge itself
  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    pa_divider #(
      .N_W(SUM_W), .D_W(CNT_W), .Q_W(SAMPLE_W)
    ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (latch_i),
      .num_i   (div_num[g]),
      .den_i   (live_cnt),
      .busy_o  (div_busy[g]),
      .quot_o  (div_quot[g])
    );
  end

  assign avg_import_o = div_quot[0];
  assign avg_export_o = div_quot[1];
  assign busy_o       = |div_busy;
endmodule

// File: rtl/period_acc_chk.sv
module period_acc_chk #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 16,
  parameter int MS_W     = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       latch_i,
  input logic        [SAMPLE_W-1:0] avg_import_o,
  input logic        [SAMPLE_W-1:0] avg_export_o,
  input logic signed [SAMPLE_W-1:0] peak_o,
  input logic        [MS_W-1:0]     elapsed_ms_o,
  input logic        [CNT_W-1:0]    count_o,
  input logic                       valid_o,
  input logic                       busy_o
);
  p_snap_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ($stable(count_o) && $stable(peak_o) && $stable(elapsed_ms_o) && $stable(valid_o)));

  p_valid_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (count_o != '0));

  p_peak_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (peak_o == '0));

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> busy_o);

  p_avg_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !busy_o) |-> (avg_import_o == '0 && avg_export_o == '0));
endmodule

bind period_acc period_acc_chk #(
  .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .MS_W(MS_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .latch_i      (latch_i),
  .avg_import_o (avg_import_o),
  .avg_export_o (avg_export_o),
  .peak_o       (peak_o),
  .elapsed_ms_o (elapsed_ms_o),
  .count_o      (count_o),
  .valid_o      (valid_o),
  .busy_o       (busy_o)
);

// File: tb/period_acc_tb_top.sv
module period_acc_tb_top;
  localparam int SW = 12;
  localparam int UW = 24;
  localparam int CW = 5;
  localparam int MW = 10;
  localparam int CNT_MAX = (1 << CW) - 1;
  localparam int MS_MAX  = (1 << MW) - 1;
  localparam int PK_MIN  = -(1 << (SW - 1));

  logic clk = 1'b0;
  logic rst_n;
  logic sample_valid, bidir, tick, latch;
  logic signed [SW-1:0] sample;
  logic [SW-1:0] avg_imp, avg_exp;
  logic signed [SW-1:0] peak;
  logic [MW-1:0] ms;
  logic [CW-1:0] count;
  logic valid, busy;

  int checks = 0;
  int failures = 0;

  longint m_imp, m_exp, e_imp, e_exp;
  int m_cnt, m_peak, m_ms, e_cnt, e_peak, e_ms;

  always #10 clk = ~clk;

  period_acc #(.SAMPLE_W(SW), .SUM_W(UW), .CNT_W(CW), .MS_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sample_valid), .sample_i(sample),
    .bidir_i(bidir), .tick_i(tick), .latch_i(latch),
    .avg_import_o(avg_imp), .avg_export_o(avg_exp), .peak_o(peak),
    .elapsed_ms_o(ms), .count_o(count), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit sv, input int s, input bit tk, input bit lt);
    sample_valid = sv; sample = SW'(s); tick = tk; latch = lt;
    if (lt) begin
      e_imp = m_imp; e_exp = m_exp; e_cnt = m_cnt; e_peak = m_peak; e_ms = m_ms;
      m_imp = 0; m_exp = 0; m_cnt = 0; m_peak = PK_MIN; m_ms = 0;
    end
    if (tk && m_ms < MS_MAX) m_ms++;
    if (sv && m_cnt < CNT_MAX) begin
      m_cnt++;
      if (s > 0) m_imp += s;
      else if (s < 0 && bidir) m_exp += -s;
      if (s > m_peak) m_peak = s;
    end
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0; tick = 1'b0; latch = 1'b0;
  endtask

  task automatic check_snap(input string tag);
    longint xi, xe;
    while (busy) @(negedge clk);
    xi = (e_cnt != 0) ? e_imp / e_cnt : 0;
    xe = (e_cnt != 0) ? e_exp / e_cnt : 0;
    chk(count == CW'(e_cnt), tag, "count", count, e_cnt);
    chk(valid == (e_cnt != 0), tag, "valid", valid, e_cnt != 0);
    chk(int'(peak) == ((e_cnt != 0) ? e_peak : 0), tag, "peak", peak, (e_cnt != 0) ? e_peak : 0);
    chk(ms == MW'(e_ms), tag, "ms", ms, e_ms);
    chk(avg_imp == SW'(xi), tag, "avg_imp", avg_imp, xi);
    chk(avg_exp == SW'(xe), tag, "avg_exp", avg_exp, xe);
  endtask

  initial begin
    #4_000_000;
    checks++; failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_valid = 1'b0; sample = '0; bidir = 1'b0; tick = 1'b0; latch = 1'b0;
    m_imp = 0; m_exp = 0; m_cnt = 0; m_peak = PK_MIN; m_ms = 0;
    e_imp = 0; e_exp = 0; e_cnt = 0; e_peak = 0; e_ms = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check_snap("R12");
    chk(busy == 1'b0, "R12", "busy", busy, 0);

    // R11 first latch covers everything since reset; R8 negative dropped
    step(1, 100, 1, 0); step(1, 200, 0, 0); step(1, -50, 1, 0);
    step(0, 0, 0, 1);
    check_snap("R11 R8");

    // R7 ticks, including one on the latch cycle
    for (int i = 0; i < 5; i++) step(1, 10 * i, 1, 0);
    step(0, 0, 1, 1);
    check_snap("R7");
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    check_snap("R7 R1");

    // R2 sample on latch cycle goes to new period
    step(1, 77, 0, 0);
    step(1, 500, 0, 1);
    check_snap("R2");
    step(0, 0, 0, 1);
    check_snap("R2 R1");

    // R4 empty period
    step(0, 0, 0, 1);
    check_snap("R4 R6");

    // R9 bidirectional
    bidir = 1'b1;
    step(1, -300, 0, 0); step(1, -100, 0, 0); step(1, 400, 0, 0); step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    check_snap("R9");

    // R6 all negative
    step(1, -7, 0, 0); step(1, -3, 0, 0); step(1, -900, 0, 0);
    step(0, 0, 0, 1);
    check_snap("R6 R9");

    // R8 negatives only, direction off
    bidir = 1'b0;
    step(1, -5, 0, 0); step(1, -9, 0, 0);
    step(0, 0, 0, 1);
    check_snap("R8");

    // R3 snapshot holds while live side runs
    for (int i = 0; i < 6; i++) step(1, 300 + i, 1, 0);
    check_snap("R3");

    // R5 count saturation, extra samples ignored
    step(0, 0, 0, 1);
    check_snap("R3 R1");
    for (int i = 0; i < CNT_MAX; i++) step(1, 1, 0, 0);
    step(1, 2000, 0, 0); step(1, 1500, 0, 0);
    step(0, 0, 0, 1);
    check_snap("R5");

    // R7 timer saturation
    for (int i = 0; i < MS_MAX + 7; i++) step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    check_snap("R7");

    // R10 sweep of period lengths and values
    for (int n = 1; n <= CNT_MAX; n++) begin
      bidir = n[0];
      for (int i = 0; i < n; i++) step(1, ((i * 37 + n * 113) % 4001) - 2000, i[1], 0);
      step(0, 0, 0, 1);
      chk(busy == 1'b1, "R10", "busy", busy, 1);
      check_snap("R10 R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule